// File: doc/BRIEF.md
# Digit-Serial Triple-Precision MAC Tap

This block is one tap of a transposed-form FIR filter that works in digit-serial format. Each word of W bits arrives as P = W/N digits of N bits, least significant digit first, with no gap between words. A marker input is high on the first digit of every word, and a second marker is high on the last digit. The block takes the low and high words of a signed product as two digit streams. It also takes the partial sum from the previous tap as three N-bit lanes. It adds the two through a one-sample delay and produces the new partial sum on three N-bit lanes, which feed the next tap.

The partial sum is three words wide (3W bits), so full precision fits with room to spare: 8-bit data, 8-bit coefficients and eight taps need 19 bits. Each lane is one precision cell, and the cells run side by side. A carry leaving one cell at the end of a word enters the cell above it on the first digit of the next word. For this reason the three lanes are skewed by one sample each: lane 1 carries the middle word of a sample one word slot after lane 0 carries its low word, and lane 2 carries the top word one slot after that. The high product word follows the same skew. The top cell adds the product's sign bit, replicated across the digit; that sign bit is latched from the high word's most significant bit on the last digit.

Top module: `dsmac_tap`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three output lanes, all internal carries, the sign latch and the delay line are cleared to zero after that edge, whatever the other inputs are.
- R2: The block has a latency of 1 cycle. The output digit of lane 0 at cycle t+1 is the low N bits of prod_lo(t) + delayed lane-0 partial digit + carry-in.
- R3: In every cell, on any digit other than the first, the carry-in is the carry-out the same cell produced on the previous digit.
- R4: On the first digit (`first_dig` high), lane 0 takes a carry-in of zero. Lane 1 takes the carry latched by lane 0 on the last digit of the previous word, and lane 2 takes the carry latched by lane 1.
- R5: On a cycle with `last_dig` high, the sign latch loads prod_hi[N-1]. Throughout the following word, the top cell's product addend is that bit replicated N times. `last_dig` must be high exactly P-1 cycles after `first_dig`.
- R6: A partial-sum digit at `acc_in*` reaches the adder after P-1 register stages, so it affects the output exactly P cycles after it is applied. The partial-sum lanes are expected one cycle after `first_dig`, the same alignment the block's own outputs have.
- R7: The lanes are reassembled as low word from lane 0 in slot k, middle word from lane 1 in slot k+1, and top word from lane 2 in slot k+2. For sample k this gives sext(product k) + partial-sum sample k-1, modulo 2^(3W). Here the product is the 2W-bit signed value {high word, low word}, and the low word of product k is driven in the slot of sample k.
- R8: The carry out of the top cell is dropped, so a 3W-bit result that overflows wraps modulo 2^(3W). For example, 1 + 0xFFFFFF gives 0, and -1 + 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_dig | input | 1 | High on the first (least significant) digit of each word |
| last_dig | input | 1 | High on the last digit of each word |
| prod_lo | input | N | Digit of the low product word |
| prod_hi | input | N | Digit of the high product word (one sample behind prod_lo) |
| acc_in0 | input | N | Previous tap partial sum, low lane |
| acc_in1 | input | N | Previous tap partial sum, middle lane |
| acc_in2 | input | N | Previous tap partial sum, top lane |
| acc_out0 | output | N | New partial sum, low lane |
| acc_out1 | output | N | New partial sum, middle lane |
| acc_out2 | output | N | New partial sum, top lane |

## Verification
Small positive products with small partial sums test only the lane-0 addition and the one-sample delay. Negative products show whether the latched sign fills the top lane, and a missing or mistimed sign latch gives a wrong top word. Values chosen to carry across word boundaries, such as 0x00FF + 0x00FF01 and 1 + 0xFFFFFF, test carry hand-off between cells and the wrap at the top. A stretch of pseudo-random signed products and partial sums then mixes all these cases, and every output digit is compared against a behavioural model on every clock.

// File: rtl/dsmac_tap.sv
`timescale 1ns/1ps
module dsmac_tap #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         first_dig,
  input  logic         last_dig,
  input  logic [N-1:0] prod_lo,
  input  logic [N-1:0] prod_hi,
  input  logic [N-1:0] acc_in0,
  input  logic [N-1:0] acc_in1,
  input  logic [N-1:0] acc_in2,
  output logic [N-1:0] acc_out0,
  output logic [N-1:0] acc_out1,
  output logic [N-1:0] acc_out2
);
  localparam int P   = W / N;
  localparam int DLY = P - 1;
  localparam int LW  = 3 * N;

  logic [LW-1:0] tail;
  logic [LW-1:0] addend;
  logic [LW-1:0] dig_q;
  logic [2:0]    cy_q;
  logic [2:0]    cin;
  logic          sgn_q;
  logic [N:0]    sum [3];

  generate
    if (DLY == 0) begin : g_nodly
      assign tail = {acc_in2, acc_in1, acc_in0};
    end else begin : g_dly
      logic [LW-1:0] pipe_q [DLY];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DLY; i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= {acc_in2, acc_in1, acc_in0};
          for (int i = 1; i < DLY; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign tail = pipe_q[DLY-1];
    end
  endgenerate

  assign addend = {{N{sgn_q}}, prod_hi, prod_lo};

  assign cin[0] = first_dig ? 1'b0    : cy_q[0];
  assign cin[1] = first_dig ? cy_q[0] : cy_q[1];
  assign cin[2] = first_dig ? cy_q[1] : cy_q[2];

  always_comb begin
    for (int k = 0; k < 3; k++)
      sum[k] = {1'b0, addend[k*N +: N]} + {1'b0, tail[k*N +: N]} + {{N{1'b0}}, cin[k]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cy_q  <= '0;
      dig_q <= '0;
      sgn_q <= 1'b0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        cy_q[k]          <= sum[k][N];
        dig_q[k*N +: N]  <= sum[k][N-1:0];
      end
      if (last_dig) sgn_q <= prod_hi[N-1];
    end
  end

  assign acc_out0 = dig_q[N-1:0];
  assign acc_out1 = dig_q[2*N-1:N];
  assign acc_out2 = dig_q[LW-1:2*N];
endmodule

// File: rtl/dsmac_tap_chk.sv
`timescale 1ns/1ps
module dsmac_tap_chk #(
  parameter int W = 8,
  parameter int N = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           first_dig,
  input logic           last_dig,
  input logic [N-1:0]   prod_lo,
  input logic [N-1:0]   prod_hi,
  input logic [3*N-1:0] tail,
  input logic [2:0]     cy_q,
  input logic           sgn_q,
  input logic [N-1:0]   acc_out0,
  input logic [N-1:0]   acc_out1,
  input logic [N-1:0]   acc_out2
);
  localparam int P  = W / N;
  localparam int PW = $clog2(P + 1) + 1;

  logic [PW-1:0] pos_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      seen_q <= 1'b0;
    end else if (first_dig) begin
      pos_q  <= PW'(1);
      seen_q <= 1'b1;
    end else if (pos_q < PW'(P)) begin
      pos_q  <= pos_q + PW'(1);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_out0 == '0 && acc_out1 == '0 && acc_out2 == '0));

  // R3
  inword_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_dig && prod_lo == '0 && tail[N-1:0] == '0) |=> acc_out0 == N'($past(cy_q[0])));

  // R4
  first_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_dig && prod_lo == '0 && tail[N-1:0] == '0) |=> acc_out0 == '0);

  // R4
  handoff_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_dig && prod_hi == '0 && tail[2*N-1:N] == '0) |=> acc_out1 == N'($past(cy_q[0])));

  // R5
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_dig && sgn_q && !cy_q[2] && tail[3*N-1:2*N] == '0) |=> acc_out2 == {N{1'b1}});

  // R5
  last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !first_dig) |-> (last_dig == (pos_q == PW'(P - 1))));

  // R6
  delay_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_dig && prod_lo == '0 && !cy_q[0]) |=> acc_out0 == $past(tail[N-1:0]));
endmodule

bind dsmac_tap dsmac_tap_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .first_dig(first_dig), .last_dig(last_dig),
  .prod_lo(prod_lo), .prod_hi(prod_hi), .tail(tail), .cy_q(cy_q), .sgn_q(sgn_q),
  .acc_out0(acc_out0), .acc_out1(acc_out1), .acc_out2(acc_out2)
);

// File: tb/tb_dsmac_tap.sv
`timescale 1ns/1ps
module tb_dsmac_tap;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int P  = W / N;
  localparam int NS = 40;
  localparam int XW = 3 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic first_dig = 1'b0, last_dig = 1'b0;
  logic [N-1:0] prod_lo = '0, prod_hi = '0;
  logic [N-1:0] acc_in0 = '0, acc_in1 = '0, acc_in2 = '0;
  logic [N-1:0] acc_out0, acc_out1, acc_out2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2*W-1:0] prod [NS];
  logic [XW-1:0]  qs   [NS];
  logic [W-1:0]   got  [3][NS+3];

  always #5 clk = ~clk;

  dsmac_tap #(.W(W), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .first_dig(first_dig), .last_dig(last_dig),
    .prod_lo(prod_lo), .prod_hi(prod_hi),
    .acc_in0(acc_in0), .acc_in1(acc_in1), .acc_in2(acc_in2),
    .acc_out0(acc_out0), .acc_out1(acc_out1), .acc_out2(acc_out2)
  );

  function automatic logic [XW-1:0] pv(int k);
    logic [2*W-1:0] p;
    p = (k < 0 || k >= NS) ? '0 : prod[k];
    return {{W{p[2*W-1]}}, p};
  endfunction

  function automatic logic [XW-1:0] qv(int k);
    return (k < 0 || k >= NS) ? '0 : qs[k];
  endfunction

  function automatic logic [XW-1:0] rv(int k);
    return pv(k) + qv(k - 1);
  endfunction

  function automatic logic [N-1:0] dg(logic [XW-1:0] v, int lane, int j);
    return v[lane*W + j*N +: N];
  endfunction

  task automatic check(string req, logic [XW-1:0] act, logic [XW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    for (int k = 0; k < 8; k++) begin
      prod[k] = 16'(k * 37 + 5);
      qs[k]   = 24'(k * 11);
    end
    for (int k = 8; k < 16; k++) begin
      prod[k] = 16'(-(k * 53 + 1));
      qs[k]   = 24'(k * 3);
    end
    for (int k = 16; k < 24; k++) begin
      prod[k] = 16'h00FF;
      qs[k]   = 24'h00FF01;
    end
    prod[18] = 16'h7FFF; qs[18] = 24'h7F8001;
    prod[19] = 16'h8000; qs[19] = 24'hFFFFFF;
    prod[20] = 16'h0001;
    prod[21] = 16'hFFFF; qs[20] = 24'h000001;
    for (int k = 24; k < NS; k++) begin
      seed = seed * 1103515245 + 12345;
      prod[k] = seed[31:16];
      seed = seed * 1103515245 + 12345;
      qs[k] = seed[31:8];
    end
  end

  initial begin
    #(64'd200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    prod_lo = '1; prod_hi = '1; acc_in0 = '1; acc_in1 = '1; acc_in2 = '1;
    first_dig = 1'b1; last_dig = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset despite active inputs
    check("R1", {acc_out2, acc_out1, acc_out0}, '0);
    rst_n = 1'b1;
    for (int t = 0; t < (NS + 3) * P; t++) begin
      int k, j, u, ku, ju;
      k = t / P; j = t % P; u = t - 1;
      first_dig = (j == 0);
      last_dig  = (j == P - 1);
      prod_lo = dg(pv(k), 0, j);
      prod_hi = dg(pv(k - 1), 1, j);
      if (u < 0) begin
        acc_in0 = '0; acc_in1 = '0; acc_in2 = '0;
      end else begin
        ku = u / P; ju = u % P;
        acc_in0 = dg(qv(ku), 0, ju);
        acc_in1 = dg(qv(ku - 1), 1, ju);
        acc_in2 = dg(qv(ku - 2), 2, ju);
      end
      @(posedge clk);
      #2;
      // R2 R3 R6: low lane digit, in-word carry, delayed partial sum
      check("R2 R3 R6 lane0", XW'(acc_out0), XW'(dg(rv(k), 0, j)));
      // R4: middle lane relies on carry hand-off from lane 0
      check("R4 lane1", XW'(acc_out1), XW'(dg(rv(k - 1), 1, j)));
      // R5: top lane relies on latched sign fill
      check("R5 lane2", XW'(acc_out2), XW'(dg(rv(k - 2), 2, j)));
      got[0][k][j*N +: N] = acc_out0;
      got[1][k][j*N +: N] = acc_out1;
      got[2][k][j*N +: N] = acc_out2;
      @(negedge clk);
    end
    for (int k = 0; k < NS; k++) begin
      logic [XW-1:0] word;
      word = {got[2][k+2], got[1][k+1], got[0][k]};
      if (k == 20 || k == 21)
        check("R8 wrap", word, '0);
      else
        check("R7 word", word, rv(k));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule